// File: doc/BRIEF.md
# Programmable Two-Level Sum-of-Products Logic Cell

This block is a small configurable logic cell that evaluates a sum of up to four product terms. Each term takes up to four literals in true polarity only. The structure is two levels of 4-input NAND gates. Four first-level gates each build one product term from a group of four input pins. A single second-level gate combines their outputs, so the result is the OR of four ANDs. The cell has 16 data inputs and one output, and every function it can realise is positive unate. A product term belongs to its own group of pins and cannot be shared.

Each input pin carries one configuration bit. When the bit is 1, the routed signal reaches the gate. When it is 0, the pin is tied to a constant that depends on where it sits in its group. The lead pin of a group (pin 4t) is tied to 0, which switches off the whole term. The other three pins of the group are tied to 1, which drops only that literal.

The 16 bits are loaded through a serial chain with a shift enable. The shift-out end gives the bits back for readback. After reset every term is off, so the output is 0 until the cell is configured. The path from the data inputs to the output is combinational. The output is only meaningful while shifting is idle.

Top module: `sopc_cell`

## Requirements
- R1: A synchronous reset clears all 16 configuration bits. After reset, `cfg_out` is 0 and `dout` is 0 for every `din` pattern.
- R2: While `cfg_en` is 1, each rising clock edge shifts `cfg_in` into the chain. After 16 shifts, the bit sent first configures pin 0 and the bit sent last configures pin 15. `cfg_out` always shows the bit that entered the chain 16 shifts earlier, which is the pin 0 bit.
- R3: While `cfg_en` is 0, the configuration holds. Clock edges and activity on `cfg_in` change neither the configuration nor `cfg_out`.
- R4: Pin p = 4t + l belongs to term t (t = 0..3) as literal l (l = 0..3). With `cfg_en` at 0, `dout` is 1 exactly when some term t has every pin with configuration bit 1 at `din` 1 and also has its lead pin (l = 0) enabled.
- R5: A non-lead pin (l = 1..3) with configuration bit 0 is tied to 1. It is removed from its term, and its `din` value has no effect on `dout`.
- R6: A lead pin (l = 0) with configuration bit 0 is tied to 0. This removes the whole term, whatever the other pins of that group are set to.
- R7: The cell is positive unate. Raising any `din` bit from 0 to 1 never lowers `dout`.
- R8: Configured for ab + acd + e, `dout` follows that function with the fourth term disabled. The mapping is: pins 0 and 1 take a and b; pins 4, 5 and 6 take a, c and d; pin 8 takes e. The configuration word is 0x0173.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst | input | 1 | Synchronous active-high reset; clears the configuration |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (oldest bit) |
| din | input | 16 | Routed data inputs; pin 4t+l is literal l of term t |
| dout | output | 1 | Sum-of-products result |

## Verification
Two operations can land on the same clock edge: clearing the configuration through reset, and shifting a bit into the chain. The bench asserts reset while `cfg_en` is high and `cfg_in` carries a 1. It then judges that reset won by reading `cfg_out` and `dout`, which must both be 0, and by checking that the next sixteen bits read back are all zero. A second overlap comes where loading hands over to evaluation. The bench drops `cfg_en` right after the last bit enters the chain. It then checks that `dout` already follows the new function in the very next cycle.

// File: rtl/sopc_pkg.sv
package sopc_pkg;
  // Tie-off value of a disabled pin: the lead literal kills the term,
  // any other literal is neutral for the AND.
  function automatic logic tie_value(input int lit);
    return (lit == 0) ? 1'b0 : 1'b1;
  endfunction
endpackage

// File: rtl/sopc_cfg_chain.sv
module sopc_cfg_chain #(
  parameter int LEN = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           ser_in,
  output logic           ser_out,
  output logic [LEN-1:0] bits
);
  logic [LEN-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= {ser_in, sr_q[LEN-1:1]};
    end
  end

  assign bits    = sr_q;
  assign ser_out = sr_q[0];
endmodule

// File: rtl/sopc_pin_gate.sv
module sopc_pin_gate #(
  parameter bit TIE = 1'b1
) (
  input  logic sig,
  input  logic keep,
  output logic pin
);
  assign pin = keep ? sig : TIE;
endmodule

// File: rtl/sopc_nand.sv
module sopc_nand #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  output logic         y
);
  assign y = ~(&a);
endmodule

// File: rtl/sopc_cell.sv
module sopc_cell #(
  parameter int TERMS = 4,
  parameter int LITS  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_en,
  input  logic                  cfg_in,
  output logic                  cfg_out,
  input  logic [TERMS*LITS-1:0] din,
  output logic                  dout
);
  import sopc_pkg::*;

  localparam int N_PINS = TERMS * LITS;

  logic [N_PINS-1:0] cfg_q;
  logic [N_PINS-1:0] pin_v;
  logic [TERMS-1:0]  term_n;

  sopc_cfg_chain #(.LEN(N_PINS)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .ser_in   (cfg_in),
    .ser_out  (cfg_out),
    .bits     (cfg_q)
  );

  for (genvar t = 0; t < TERMS; t++) begin : g_term
    for (genvar l = 0; l < LITS; l++) begin : g_lit
      sopc_pin_gate #(.TIE(tie_value(l))) u_pin (
        .sig  (din[t*LITS+l]),
        .keep (cfg_q[t*LITS+l]),
        .pin  (pin_v[t*LITS+l])
      );
    end
    sopc_nand #(.W(LITS)) u_first (
      .a (pin_v[t*LITS +: LITS]),
      .y (term_n[t])
    );
  end

  sopc_nand #(.W(TERMS)) u_second (
    .a (term_n),
    .y (dout)
  );
endmodule

// File: rtl/sopc_cell_chk.sv
module sopc_cell_chk #(
  parameter int TERMS = 4,
  parameter int LITS  = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_en,
  input logic                  cfg_in,
  input logic                  cfg_out,
  input logic [TERMS*LITS-1:0] din,
  input logic                  dout,
  input logic [TERMS*LITS-1:0] cfg_q
);
  localparam int N_PINS = TERMS * LITS;

  function automatic logic [N_PINS-1:0] head_mask();
    logic [N_PINS-1:0] m = '0;
    for (int t = 0; t < TERMS; t++) m[t*LITS] = 1'b1;
    return m;
  endfunction

  localparam logic [N_PINS-1:0] HEADS = head_mask();

  logic any_head;
  logic all_enabled_high;
  assign any_head         = |(cfg_q & HEADS);
  assign all_enabled_high = ((din & cfg_q) == cfg_q);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cfg_q == '0 && !cfg_out)); // R1
  AST_SHIFT_ENTERS: assert property (@(posedge clk) disable iff (rst) cfg_en |=> (cfg_q[N_PINS-1] == $past(cfg_in))); // R2
  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (rst) !cfg_en |=> $stable(cfg_q)); // R3
  AST_NO_TERM_ZERO: assert property (@(posedge clk) disable iff (rst) (!cfg_en && !any_head) |-> !dout); // R6
  AST_FULL_MATCH_ONE: assert property (@(posedge clk) disable iff (rst) (!cfg_en && any_head && all_enabled_high) |-> dout); // R4
endmodule

bind sopc_cell sopc_cell_chk #(.TERMS(TERMS), .LITS(LITS)) u_chk (.*);

// File: tb/test_sopc_cell.sv
`timescale 1ns/1ps
module test_sopc_cell;
  localparam int TERMS = 4;
  localparam int LITS  = 4;
  localparam int NP    = TERMS * LITS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_en = 1'b0;
  logic          cfg_in = 1'b0;
  logic          cfg_out;
  logic [NP-1:0] din = '0;
  logic          dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sopc_cell #(.TERMS(TERMS), .LITS(LITS)) i_sopc_cell (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .cfg_out(cfg_out), .din(din), .dout(dout)
  );

  // {cfg, din, expected}
  localparam logic [32:0] VEC [10] = '{
    {16'h0173, 16'h0013, 1'b1},  // R8 ab true
    {16'h0173, 16'h0011, 1'b0},  // R8 only a
    {16'h0173, 16'h0100, 1'b1},  // R8 e
    {16'h0173, 16'h0070, 1'b1},  // R8 acd
    {16'h0173, 16'hF000, 1'b0},  // R6 disabled term high
    {16'h0000, 16'hFFFF, 1'b0},  // R6 nothing enabled
    {16'h000E, 16'hFFFF, 1'b0},  // R6 lead off kills term
    {16'h1000, 16'h1000, 1'b1},  // R5 other pins tied high
    {16'hFFFF, 16'h7777, 1'b0},  // R4 every term misses one
    {16'hFFFF, 16'h0F00, 1'b1}   // R4 term 2 full
  };

  function automatic logic ref_out(input logic [NP-1:0] c, input logic [NP-1:0] d);
    logic r = 1'b0;
    for (int t = 0; t < TERMS; t++) begin
      logic p = c[t*LITS] & d[t*LITS];
      for (int l = 1; l < LITS; l++) p &= (!c[t*LITS+l]) | d[t*LITS+l];
      r |= p;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // called at a negedge; leaves at a negedge with cfg_en low
  task automatic load(input logic [NP-1:0] c);
    for (int i = 0; i < NP; i++) begin
      cfg_en = 1'b1;
      cfg_in = c[i];
      @(negedge clk);
    end
    cfg_en = 1'b0;
    cfg_in = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] c, d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    din = '1;
    @(negedge clk);
    check("R1 reset cfg_out", cfg_out, 1'b0);
    check("R1 reset dout", dout, 1'b0);

    // table walk
    for (int i = 0; i < 10; i++) begin
      load(VEC[i][32:17]);
      din = VEC[i][16:1];
      #1;
      check($sformatf("R4 vector %0d", i), dout, VEC[i][0]);
      check($sformatf("R4 vector %0d model", i), dout, ref_out(VEC[i][32:17], VEC[i][16:1]));
      @(negedge clk);
    end

    // R2 readback order: pin 0 bit comes out first
    c = 16'hA5C3;
    load(c);
    for (int i = 0; i < NP; i++) begin
      check($sformatf("R2 readback bit %0d", i), cfg_out, c[i]);
      cfg_en = 1'b1;
      cfg_in = 1'b0;
      @(negedge clk);
    end
    cfg_en = 1'b0;

    // R3 hold: cfg_in toggles without enable
    c = 16'h0173;
    load(c);
    for (int i = 0; i < 8; i++) begin
      cfg_in = i[0];
      @(negedge clk);
    end
    din = 16'h0100;
    #1;
    check("R3 config held dout", dout, 1'b1);
    for (int i = 0; i < NP; i++) begin
      check($sformatf("R3 held bit %0d", i), cfg_out, c[i]);
      cfg_en = 1'b1;
      cfg_in = 1'b0;
      @(negedge clk);
    end
    cfg_en = 1'b0;

    // R5: disabled non-lead pins have no effect
    load(16'h0001);
    din = 16'h0001;
    #1;
    check("R5 ignored pins low", dout, 1'b1);
    din = 16'h000F;
    #1;
    check("R5 ignored pins high", dout, 1'b1);
    din = 16'hFFFE;
    #1;
    check("R5 lead low", dout, 1'b0);
    @(negedge clk);

    // random configurations against model, plus R7 monotonicity
    for (int k = 0; k < 20; k++) begin
      c = 16'($urandom);
      load(c);
      for (int j = 0; j < 64; j++) begin
        logic lo;
        d = 16'($urandom);
        din = d;
        #1;
        check("R4 random model", dout, ref_out(c, d));
        lo = dout;
        din = d | (16'h1 << ($urandom % NP));
        #1;
        if (lo) check("R7 monotonic", dout, 1'b1);
      end
      @(negedge clk);
    end

    // same-cycle: reset while shifting a 1
    load(16'hFFFF);
    cfg_en = 1'b1;
    cfg_in = 1'b1;
    rst    = 1'b1;
    @(negedge clk);
    rst    = 1'b0;
    cfg_en = 1'b0;
    din    = '1;
    #1;
    check("R1 reset beats shift cfg_out", cfg_out, 1'b0);
    check("R1 reset beats shift dout", dout, 1'b0);
    for (int i = 0; i < NP; i++) begin
      check($sformatf("R1 cleared bit %0d", i), cfg_out, 1'b0);
      cfg_en = 1'b1;
      cfg_in = 1'b0;
      @(negedge clk);
    end
    cfg_en = 1'b0;

    // handover: enable drops right after last bit, evaluate next cycle
    din = 16'h0013;
    load(16'h0173);
    check("R8 handover ab", dout, 1'b1);
    din = 16'h0011;
    #1;
    check("R8 handover a only", dout, 1'b0);

    done = 1;
    summary();
    $finish;
  end
endmodule